// File: doc/BRIEF.md
# Line Refill Cache Controller

This block is a direct-mapped read cache of 16 lines with four 32-bit words per line, together with the bus sequencer that refills it. A CPU-side lookup port takes an address, a function code, a cachable flag and two enables: one for the cache and one for burst refill. When the tag matches and the addressed word is valid, the port returns the data in the same cycle. Any other lookup starts a bus read.

For a cachable read that misses, the controller picks the kind of refill for that access alone. On a tag mismatch, or when every word of the line is invalid, it asks for a burst. If burst refill is disabled, or if the line already holds some valid words, it fetches only the one missing word. A burst goes ahead only when the slave acknowledges it. The burst starts at the missed word and wraps through the line. One word arrives with each termination strobe, and the burst may stop early when the strobes stop.

Reads that are non-cachable, or made while the cache is disabled, go straight to the bus. The data is handed to the CPU and the cache is left unchanged.

Top module: `line_refill_cache`

## Requirements
- R1: The address is split as byte offset [1:0], word index [3:2], line index [7:4] and upper address [31:8]. The stored tag is the function code together with the upper address. A lookup reports `cpu_hit`, `cpu_ack` and the stored word in the same cycle when the tag of the indexed line matches and the indexed word is valid.
- R2: After a synchronous active-low reset, every word is invalid, every tag is zero, the bus is idle and no lookup hits.
- R3: On a cachable, enabled miss with a tag mismatch, the new tag is written and all four valid bits of the line are cleared before any word is stored. If burst refill is enabled, `bus_burst_req` is driven with `bus_req`.
- R4: A cachable, enabled miss whose tag matches but whose line has no valid word asks for a burst when burst refill is enabled.
- R5: A miss whose tag matches while at least one other word of the line is valid fetches only the addressed word, with `bus_burst_req` low, even if the slave acknowledges a burst.
- R6: If `bus_burst_ack` is low when the first word's `bus_term` arrives, only that word is transferred, and `bus_req` is low from the next cycle.
- R7: An acknowledged burst carries words at word indices start, start+1, start+2 and start+3 modulo 4 on `bus_addr[3:2]`, one per `bus_term` cycle. Each word is stored and marked valid.
- R8: After an acknowledged first word, a cycle with no `bus_term` ends the burst. Words already received stay valid and the rest stay invalid.
- R9: A read with `cpu_cachable` low or `cache_en` low is served by a single bus word with `bus_burst_req` low and changes no tag, valid bit or stored word.
- R10: With `burst_en` low, a tag-mismatch miss replaces the tag and fetches only the addressed word.
- R11: For a miss, `cpu_ack` is asserted with `cpu_rdata` equal to `bus_data` in the cycle the first `bus_term` arrives, and is not asserted for later burst words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Lookup request |
| cpu_addr | input | 32 | Lookup byte address |
| cpu_fc | input | 3 | Function code, part of the tag |
| cpu_cachable | input | 1 | Access may be cached |
| cache_en | input | 1 | Cache enable |
| burst_en | input | 1 | Burst refill enable |
| cpu_hit | output | 1 | Same-cycle hit |
| cpu_ack | output | 1 | Read data valid (hit or first bus word) |
| cpu_rdata | output | 32 | Read data |
| bus_req | output | 1 | Bus read in progress |
| bus_burst_req | output | 1 | Burst requested |
| bus_addr | output | 32 | Address of the current word |
| bus_burst_ack | input | 1 | Slave accepts the burst (sampled with the first word) |
| bus_term | input | 1 | Synchronous termination, one per word |
| bus_data | input | 32 | Read word from the slave |

## Verification
A hit, its data and the miss decision are combinational and are checked 2 ns after inputs change in the same low clock phase. A miss is accepted at the next rising edge, so `bus_req`, `bus_burst_req` and the first `bus_addr` are checked at the following falling edge. `cpu_ack` is checked in the same phase that `bus_term` is driven. Each word's storage and valid bit take effect at the edge that samples its strobe. The bench therefore probes line contents only after `bus_req` has been seen low one full cycle after the last strobe. Probes drop `cpu_req` before the next rising edge, so a probe that misses never starts a refill.

// File: rtl/lrc_pkg.sv
`timescale 1ns/1ps
// Shared types for the line refill cache.
// Assumes: used by the sequencer and top only; no parameters live here.
package lrc_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FIRST = 2'd1,
        SQ_BURST = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lrc_tag_store.sv
`timescale 1ns/1ps
// Tag and per-word valid storage, one entry per line.
// Reads are combinational for one line. A tag write replaces the tag and clears
// all of the line's valid bits. A set marks one word valid.
// Assumes: a tag write and a set never target the same cycle (sequencer order).
module lrc_tag_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int TAG_BW = 27,
    localparam int LINE_W = $clog2(LINES),
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output logic [TAG_BW-1:0] rd_tag,
    output logic [WORDS-1:0]  rd_valid,
    input  logic              tag_we,
    input  logic [LINE_W-1:0] tag_line,
    input  logic [TAG_BW-1:0] tag_val,
    input  logic              set_we,
    input  logic [LINE_W-1:0] set_line,
    input  logic [IDX_W-1:0]  set_idx,
    output logic [LINES*WORDS-1:0] valid_flat
);
    logic [TAG_BW-1:0] tag_q   [LINES];
    logic [WORDS-1:0]  valid_q [LINES];

    // Reset, tag replacement with valid clear, and per-word valid set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]   <= '0;
                valid_q[i] <= '0;
            end
        end else begin
            if (tag_we) begin
                tag_q[tag_line]   <= tag_val;
                valid_q[tag_line] <= '0;
            end
            if (set_we)
                valid_q[set_line][set_idx] <= 1'b1;
        end
    end

    // Combinational read of the indexed line.
    always_comb begin
        rd_tag   = tag_q[rd_line];
        rd_valid = valid_q[rd_line];
    end

    // Flattened valid bits for checks in the top.
    for (genvar g = 0; g < LINES; g++) begin : g_flat
        assign valid_flat[g*WORDS +: WORDS] = valid_q[g];
    end

    // Checker state: line written by the previous tag write.
    logic [LINE_W-1:0] chk_line;
    always_ff @(posedge clk) chk_line <= tag_line;

    // R3: a tag replacement leaves the line with no valid word.
    a_r3_tag_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |=> (valid_q[chk_line] == '0));
endmodule

// File: rtl/lrc_data_store.sv
`timescale 1ns/1ps
// Data array of LINES x WORDS words, one write port and one combinational read.
// Assumes: no reset of contents; words are qualified by the valid bits.
module lrc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int LINE_W = $clog2(LINES),
    localparam int IDX_W  = $clog2(WORDS),
    localparam int DEPTH  = LINES * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store one arriving word.
    always_ff @(posedge clk) begin
        if (we)
            mem_q[{wr_line, wr_idx}] <= wr_data;
    end

    // Combinational read for same-cycle hits.
    assign rd_data = mem_q[{rd_line, rd_idx}];

    // Checker state: previous write slot and data.
    logic [LINE_W+IDX_W-1:0] chk_slot;
    logic [DATA_W-1:0]       chk_data;
    always_ff @(posedge clk) begin
        chk_slot <= {wr_line, wr_idx};
        chk_data <= wr_data;
    end

    // R7: each received word is held in its slot on the next cycle.
    a_r7_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[chk_slot] == chk_data));
endmodule

// File: rtl/lrc_fill_seq.sv
`timescale 1ns/1ps
// Bus-side refill sequencer.
// Latches a miss, issues the first word, and if a burst was asked for and
// acknowledged on the first strobe, takes the rest of the line wrapping from the
// missed word. A strobe-free cycle inside a burst ends it.
// Assumes: the slave holds bus_data valid in every bus_term cycle.
module lrc_fill_seq
    import lrc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 4,
    parameter int LINE_W = 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int OFF_W = 2,
    localparam int UP_W  = ADDR_W - OFF_W - IDX_W - LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              want_burst,
    input  logic              want_store,
    input  logic              bus_term,
    input  logic              bus_burst_ack,
    output logic              idle,
    output logic              first_done,
    output logic              wr_en,
    output logic [LINE_W-1:0] wr_line,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              bus_req,
    output logic              bus_burst_req,
    output logic [ADDR_W-1:0] bus_addr
);
    seq_state_t        state_q;
    logic [UP_W-1:0]   up_q;
    logic [LINE_W-1:0] line_q;
    logic [IDX_W-1:0]  idx_q;
    logic [OFF_W-1:0]  off_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              burst_q;
    logic              store_q;
    logic [IDX_W-1:0]  cur_idx;

    // State, latched miss address and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            up_q    <= '0;
            line_q  <= '0;
            idx_q   <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
            burst_q <= 1'b0;
            store_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start) begin
                    state_q <= SQ_FIRST;
                    {up_q, line_q, idx_q, off_q} <= start_addr;
                    cnt_q   <= '0;
                    burst_q <= want_burst;
                    store_q <= want_store;
                end
                SQ_FIRST: if (bus_term) begin
                    if (burst_q && bus_burst_ack) begin
                        state_q <= SQ_BURST;
                        cnt_q   <= IDX_W'(1);
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_BURST: begin
                    if (!bus_term || cnt_q == IDX_W'(WORDS - 1))
                        state_q <= SQ_IDLE;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Bus outputs and the per-word write strobe.
    always_comb begin
        cur_idx       = idx_q + cnt_q;
        idle          = (state_q == SQ_IDLE);
        bus_req       = !idle;
        bus_burst_req = !idle && burst_q;
        bus_addr      = {up_q, line_q, cur_idx, (cnt_q == '0) ? off_q : OFF_W'(0)};
        first_done    = (state_q == SQ_FIRST) && bus_term;
        wr_en         = !idle && bus_term && store_q;
        wr_line       = line_q;
        wr_idx        = cur_idx;
    end

    // R3: a burst request is only ever made inside a bus read.
    a_r3_burst_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst_req |-> bus_req);
    // R6: a first word without burst acceptance closes the read.
    a_r6_single_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_FIRST && bus_term && !(burst_q && bus_burst_ack)) |=> !bus_req);
    // R8: a gap in the strobes ends a burst.
    a_r8_gap_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_BURST && !bus_term) |=> idle);
endmodule

// File: rtl/line_refill_cache.sv
`timescale 1ns/1ps
// Direct-mapped read cache with per-access choice of single-word or burst refill.
// Looks up tag and valid bits, answers hits in the same cycle, and hands misses
// to the refill sequencer. Non-cachable or disabled reads bypass storage.
// Assumes: the CPU drops cpu_req after cpu_ack.
module line_refill_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int FC_W   = 3,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    localparam int OFF_W  = 2,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = $clog2(LINES),
    localparam int UP_W   = ADDR_W - OFF_W - IDX_W - LINE_W,
    localparam int TAG_BW = FC_W + UP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [FC_W-1:0]   cpu_fc,
    input  logic              cpu_cachable,
    input  logic              cache_en,
    input  logic              burst_en,
    output logic              cpu_hit,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic              bus_burst_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_burst_ack,
    input  logic              bus_term,
    input  logic [DATA_W-1:0] bus_data
);
    logic [LINE_W-1:0] lk_line;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_BW-1:0] lk_tag, rd_tag;
    logic [WORDS-1:0]  rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [LINES*WORDS-1:0] valid_flat;
    logic use_cache, tag_match, start, want_burst, tag_we;
    logic idle, first_done, wr_en;
    logic [LINE_W-1:0] wr_line;
    logic [IDX_W-1:0]  wr_idx;

    // Address split, hit test and refill choice.
    always_comb begin
        lk_idx     = cpu_addr[OFF_W +: IDX_W];
        lk_line    = cpu_addr[OFF_W+IDX_W +: LINE_W];
        lk_tag     = {cpu_fc, cpu_addr[ADDR_W-1 -: UP_W]};
        use_cache  = cpu_cachable && cache_en;
        tag_match  = (rd_tag == lk_tag);
        cpu_hit    = idle && cpu_req && use_cache && tag_match && rd_valid[lk_idx];
        start      = idle && cpu_req && !cpu_hit;
        want_burst = use_cache && burst_en && (!tag_match || rd_valid == '0);
        tag_we     = start && use_cache && !tag_match;
        cpu_ack    = cpu_hit || first_done;
        cpu_rdata  = cpu_hit ? rd_data : bus_data;
    end

    lrc_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_BW(TAG_BW)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_line(lk_line), .rd_tag(rd_tag), .rd_valid(rd_valid),
        .tag_we(tag_we), .tag_line(lk_line), .tag_val(lk_tag),
        .set_we(wr_en), .set_line(wr_line), .set_idx(wr_idx),
        .valid_flat(valid_flat)
    );

    lrc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n),
        .rd_line(lk_line), .rd_idx(lk_idx), .rd_data(rd_data),
        .we(wr_en), .wr_line(wr_line), .wr_idx(wr_idx), .wr_data(bus_data)
    );

    lrc_fill_seq #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_addr(cpu_addr),
        .want_burst(want_burst), .want_store(use_cache),
        .bus_term(bus_term), .bus_burst_ack(bus_burst_ack),
        .idle(idle), .first_done(first_done),
        .wr_en(wr_en), .wr_line(wr_line), .wr_idx(wr_idx),
        .bus_req(bus_req), .bus_burst_req(bus_burst_req), .bus_addr(bus_addr)
    );

    // R9: a bypass read leaves every valid bit as it was.
    a_r9_bypass_no_valid_change: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !use_cache) |=> (valid_flat == $past(valid_flat)));
    // R1: a hit never coincides with a bus read.
    a_r1_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> !bus_req);
    // R11: the CPU is acknowledged for at most one word per bus read.
    a_r11_ack_first_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && cpu_ack) |=> !cpu_ack);
endmodule

// File: tb/line_refill_cache_test.sv
`timescale 1ns/1ps
module line_refill_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [2:0]  cpu_fc = '0;
    logic        cpu_cachable = 1'b1;
    logic        cache_en = 1'b1;
    logic        burst_en = 1'b1;
    logic        cpu_hit, cpu_ack, bus_req, bus_burst_req;
    logic [31:0] cpu_rdata, bus_addr;
    logic        bus_burst_ack = 1'b0;
    logic        bus_term = 1'b0;
    logic [31:0] bus_data = '0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    line_refill_cache uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_fc(cpu_fc), .cpu_cachable(cpu_cachable), .cache_en(cache_en),
        .burst_en(burst_en), .cpu_hit(cpu_hit), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_burst_req(bus_burst_req),
        .bus_addr(bus_addr), .bus_burst_ack(bus_burst_ack), .bus_term(bus_term),
        .bus_data(bus_data)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Lookup that never starts a refill: request dropped before the rising edge.
    task automatic probe(input logic [31:0] a, input logic [2:0] fc, input logic exp_hit,
                         input logic [31:0] exp_data, input string rq);
        @(negedge clk);
        cpu_addr = a; cpu_fc = fc; cpu_cachable = 1'b1; cache_en = 1'b1; cpu_req = 1'b1;
        #2;
        chk(rq, {31'b0, cpu_hit}, {31'b0, exp_hit});
        if (exp_hit) begin
            chk(rq, {31'b0, cpu_ack}, 32'd1);
            chk(rq, cpu_rdata, exp_data);
        end
        #3 cpu_req = 1'b0;
    endtask

    // Miss followed by n strobed words; checks burst request, addresses and ack.
    task automatic fill(input logic [31:0] a, input logic [2:0] fc, input logic cach,
                        input logic en, input logic exp_burst, input logic ack,
                        input int n, input logic [31:0] base, input string rq);
        @(negedge clk);
        cpu_addr = a; cpu_fc = fc; cpu_cachable = cach; cache_en = en; cpu_req = 1'b1;
        #2 chk(rq, {31'b0, cpu_hit}, 32'd0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cpu_req = 1'b0;
            chk(rq, {31'b0, bus_req}, 32'd1);
            chk(rq, {31'b0, bus_burst_req}, {31'b0, exp_burst});
            chk(rq, bus_addr, {a[31:4], 2'(a[3:2] + 2'(k)), 2'b00});
            bus_term = 1'b1; bus_data = base + 32'(k); bus_burst_ack = ack;
            #2;
            chk("R11", {31'b0, cpu_ack}, {31'b0, (k == 0)});
            if (k == 0) chk("R11", cpu_rdata, base);
        end
        @(negedge clk);
        bus_term = 1'b0; bus_burst_ack = 1'b0;
        @(negedge clk);
        chk(rq, {31'b0, bus_req}, 32'd0);
        cpu_cachable = 1'b1; cache_en = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R2", {31'b0, bus_req}, 32'd0);
        chk("R2", {31'b0, cpu_ack}, 32'd0);
        probe(32'h0000_0010, 3'd0, 1'b0, 32'h0, "R2");
    endtask

    // R4: reset tag zero matches, line all invalid, burst from word 1.
    task automatic t_all_invalid_burst();
        fill(32'h0000_0014, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 4, 32'hA000_0000, "R4");
        probe(32'h0000_0014, 3'd0, 1'b1, 32'hA000_0000, "R7");
        probe(32'h0000_0018, 3'd0, 1'b1, 32'hA000_0001, "R7");
        probe(32'h0000_001C, 3'd0, 1'b1, 32'hA000_0002, "R7");
        probe(32'h0000_0010, 3'd0, 1'b1, 32'hA000_0003, "R1");
    endtask

    // R3/R7: tag mismatch with function code 5, wrap from word 2.
    task automatic t_miss_burst_wrap();
        fill(32'h0000_1238, 3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 4, 32'hB000_0000, "R3");
        probe(32'h0000_1230, 3'd5, 1'b1, 32'hB000_0002, "R7");
        probe(32'h0000_1234, 3'd5, 1'b1, 32'hB000_0003, "R7");
        probe(32'h0000_1234, 3'd4, 1'b0, 32'h0, "R1");
    endtask

    // R6/R3: new tag on line 3, slave refuses burst; old words cleared.
    task automatic t_no_ack();
        fill(32'h0000_5634, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1, 32'hC000_0000, "R6");
        probe(32'h0000_5634, 3'd5, 1'b1, 32'hC000_0000, "R6");
        probe(32'h0000_5630, 3'd5, 1'b0, 32'h0, "R3");
        probe(32'h0000_5638, 3'd5, 1'b0, 32'h0, "R3");
        probe(32'h0000_1238, 3'd5, 1'b0, 32'h0, "R3");
    endtask

    // R5: matching tag with a valid neighbour fetches one word despite ack.
    task automatic t_single_entry();
        fill(32'h0000_5630, 3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1, 32'hD000_0000, "R5");
        probe(32'h0000_5630, 3'd5, 1'b1, 32'hD000_0000, "R5");
        probe(32'h0000_563C, 3'd5, 1'b0, 32'h0, "R5");
    endtask

    // R8: burst on line 4 from word 1 stops after two words.
    task automatic t_early_stop();
        fill(32'h0000_9A44, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 2, 32'hE000_0000, "R8");
        probe(32'h0000_9A44, 3'd2, 1'b1, 32'hE000_0000, "R8");
        probe(32'h0000_9A48, 3'd2, 1'b1, 32'hE000_0001, "R8");
        probe(32'h0000_9A4C, 3'd2, 1'b0, 32'h0, "R8");
        probe(32'h0000_9A40, 3'd2, 1'b0, 32'h0, "R8");
    endtask

    // R10: burst refill disabled, tag miss on line 8.
    task automatic t_burst_disabled();
        burst_en = 1'b0;
        fill(32'h0000_7788, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1, 32'hF000_0000, "R10");
        burst_en = 1'b1;
        probe(32'h0000_7788, 3'd1, 1'b1, 32'hF000_0000, "R10");
        probe(32'h0000_778C, 3'd1, 1'b0, 32'h0, "R10");
    endtask

    // R9: non-cachable and cache-disabled reads change nothing.
    task automatic t_bypass();
        fill(32'h0000_0014, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1, 32'h1111_0000, "R9");
        probe(32'h0000_0014, 3'd0, 1'b1, 32'hA000_0000, "R9");
        fill(32'h0000_AB14, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1, 32'h2222_0000, "R9");
        probe(32'h0000_0014, 3'd0, 1'b1, 32'hA000_0000, "R9");
        probe(32'h0000_AB14, 3'd0, 1'b0, 32'h0, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_all_invalid_burst();
        t_miss_burst_wrap();
        t_no_ack();
        t_single_entry();
        t_early_stop();
        t_burst_disabled();
        t_bypass();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule